// File: doc/BRIEF.md
# Physical Register Usage Table

This block holds bookkeeping for every physical register of the leading thread in a redundantly threaded core. From this bookkeeping it decides each cycle which registers can go back to the free pool early, before the instruction that overwrites them has committed.

For each physical register it stores:
- the number of dispatched readers still waiting in the issue queue;
- whether a newer writer of the same logical register has been dispatched;
- whether the producing instruction has committed and its value has been placed in the checker value queue, together with that queue slot;
- the producing instruction number.

A register is returned as soon as three things are true: it has no waiting readers, its value is safe in the checker queue, and a newer writer of its logical register exists. Each early release carries the information that the overwriter's reorder-buffer entry needs in order to restore the value on a squash:
- a deallocate flag;
- the logical register;
- the overwriter's reorder-buffer index;
- the producer's instruction number;
- the queue slot.

If the overwriter commits before the register has been released early, the register is returned the conventional way, with the deallocate flag clear.

The scan over all entries runs every cycle, not only when the free pool runs low. At most `REL_SLOTS` registers are pushed per cycle, lowest index first, and the rest wait for later cycles. The rename table and the copy-back of saved values are outside this block.

Top module: `preg_usage_table`

## Requirements
- R1: After reset no entry is live, every reader count is zero, and no release is presented until events make an entry eligible.
- R2: The reader count of a register rises by one per dispatch-port hit and falls by one per issue-port hit. A register with a non-zero count is never released early.
- R3: An early release needs all three conditions: count zero, producer committed with its queue slot recorded, and overwrite seen. With any one of them missing, nothing is released.
- R4: A release is presented in the cycle after the clock edge that captured the last enabling event. It is presented for exactly one cycle, and the entry is cleared at the following edge.
- R5: An early release reports relDealloc = 1. It also reports the logical register and reorder-buffer index from the overwrite event, the instruction number from allocation and the queue slot from commit.
- R6: When more entries are eligible than there are release slots, slot 0 carries the lowest eligible index and each higher slot the next higher index. At most REL_SLOTS registers are released per cycle, and the remainder follow in later cycles.
- R7: A released entry is cleared. A later overwriter commit for that register produces no second release, and a reallocated register inherits no stale commit or overwrite state.
- R8: An overwriter commit on a live register that is not yet eligible releases it in the next cycle with relDealloc = 0, whatever its other state.
- R9: A squash clears the overwrite flag and the reader count of every live entry. Such an entry is released early only after a fresh overwrite event.
- R10: A dispatch and an issue that hit the same register in the same cycle leave its count unchanged.
- R11: An overwriter commit arriving in the cycle in which the register is already presented for early release yields a single release with relDealloc = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | A physical register is assigned to a new producer |
| allocPreg | input | 4 | Register being assigned |
| allocInum | input | 8 | Instruction number of the producer |
| dispValid | input | 2 | Per dispatch port: a reader of dispPreg was dispatched |
| dispPreg | input | 2x4 | Register read by each dispatched reader |
| issValid | input | 2 | Per issue port: a reader left the issue queue |
| issPreg | input | 2x4 | Register read by each departing reader |
| ovwValid | input | 1 | A newer writer of the register's logical register was dispatched |
| ovwPreg | input | 4 | Previous mapping being overwritten |
| ovwLreg | input | 5 | Logical register of that mapping |
| ovwRobIdx | input | 7 | Reorder-buffer index of the overwriter |
| commitValid | input | 1 | Producer committed and its value entered the checker queue |
| commitPreg | input | 4 | Register of the committed producer |
| commitQAddr | input | 9 | Checker queue slot holding the value |
| ovwCommitValid | input | 1 | The overwriter of a register committed |
| ovwCommitPreg | input | 4 | Register whose overwriter committed |
| squashValid | input | 1 | Pipeline squash |
| relValid | output | 2 | Per slot: a register is pushed to the free list |
| relPreg | output | 2x4 | Released register per slot |
| relInum | output | 2x8 | Producer instruction number per slot |
| relLreg | output | 2x5 | Logical register per slot |
| relRobIdx | output | 2x7 | Overwriter reorder-buffer index per slot |
| relQAddr | output | 2x9 | Checker queue slot per slot |
| relDealloc | output | 2 | 1 for an early release, 0 for a conventional one |

## Verification
Two functions of this block can fall in the same cycle: an entry already presented for early release, and the commit of its overwriter for that same register. The bench provokes this by driving the overwriter commit exactly in the cycle in which the early release is visible. It expects one push with the deallocate flag set and nothing afterwards; the scoreboard reports any extra push as unexpected. The same-cycle dispatch and issue on one register is judged the same way: the register must stay held until the remaining reader departs.

// File: rtl/put_pkg.sv
package put_pkg;
  parameter int NUM_PREGS = 16;
  parameter int INUM_W    = 8;
  parameter int LREG_W    = 5;
  parameter int ROB_W     = 7;
  parameter int QADDR_W   = 9;
  parameter int CNT_W     = 3;
  localparam int PREG_W   = $clog2(NUM_PREGS);
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  typedef struct packed {
    logic                live;
    logic                ovw;
    logic                inQ;
    logic                ovwDone;
    logic [CNT_W-1:0]    cnt;
    logic [QADDR_W-1:0]  qAddr;
    logic [INUM_W-1:0]   inum;
    logic [LREG_W-1:0]   lreg;
    logic [ROB_W-1:0]    robIdx;
  } entry_t;

  typedef struct packed {
    logic [NUM_PREGS-1:0] clrMask;
  } strobe_t;
endpackage

// File: rtl/put_datapath.sv
module put_datapath
  import put_pkg::*;
#(
  parameter int DISP_W = 2,
  parameter int ISS_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           allocValid,
  input  logic [PREG_W-1:0]              allocPreg,
  input  logic [INUM_W-1:0]              allocInum,
  input  logic [DISP_W-1:0]              dispValid,
  input  logic [DISP_W-1:0][PREG_W-1:0]  dispPreg,
  input  logic [ISS_W-1:0]               issValid,
  input  logic [ISS_W-1:0][PREG_W-1:0]   issPreg,
  input  logic                           ovwValid,
  input  logic [PREG_W-1:0]              ovwPreg,
  input  logic [LREG_W-1:0]              ovwLreg,
  input  logic [ROB_W-1:0]               ovwRobIdx,
  input  logic                           commitValid,
  input  logic [PREG_W-1:0]              commitPreg,
  input  logic [QADDR_W-1:0]             commitQAddr,
  input  logic                           ovwCommitValid,
  input  logic [PREG_W-1:0]              ovwCommitPreg,
  input  logic                           squashValid,
  input  strobe_t                        strb,
  output entry_t [NUM_PREGS-1:0]         ents
);

  logic [CNT_W-1:0] incCnt [NUM_PREGS];
  logic [CNT_W-1:0] decCnt [NUM_PREGS];

  always_comb begin
    for (int i = 0; i < NUM_PREGS; i++) begin
      incCnt[i] = '0;
      decCnt[i] = '0;
      for (int p = 0; p < DISP_W; p++)
        if (dispValid[p] && dispPreg[p] == PREG_W'(i)) incCnt[i] = incCnt[i] + CNT_W'(1);
      for (int p = 0; p < ISS_W; p++)
        if (issValid[p] && issPreg[p] == PREG_W'(i)) decCnt[i] = decCnt[i] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents <= '0;
    end else begin
      for (int i = 0; i < NUM_PREGS; i++) begin
        if (strb.clrMask[i]) begin
          ents[i] <= '0;
        end else if (allocValid && allocPreg == PREG_W'(i)) begin
          ents[i]      <= '0;
          ents[i].live <= 1'b1;
          ents[i].inum <= allocInum;
        end else if (ents[i].live) begin
          if (commitValid && commitPreg == PREG_W'(i)) begin
            ents[i].inQ   <= 1'b1;
            ents[i].qAddr <= commitQAddr;
          end
          if (ovwCommitValid && ovwCommitPreg == PREG_W'(i))
            ents[i].ovwDone <= 1'b1;
          if (squashValid) begin
            ents[i].ovw <= 1'b0;
            ents[i].cnt <= '0;
          end else begin
            ents[i].cnt <= ents[i].cnt + incCnt[i] - decCnt[i];
            if (ovwValid && ovwPreg == PREG_W'(i)) begin
              ents[i].ovw    <= 1'b1;
              ents[i].lreg   <= ovwLreg;
              ents[i].robIdx <= ovwRobIdx;
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PREGS; g++) begin : gEntChk
    logic [CNT_W:0] upSum;
    assign upSum = {1'b0, ents[g].cnt} + {1'b0, incCnt[g]};

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ents[g].live && !squashValid && !strb.clrMask[g]) |->
        (upSum - {1'b0, decCnt[g]} <= (CNT_W+1)'(CNT_MAX)));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ents[g].live && !squashValid && !strb.clrMask[g]) |-> (upSum >= {1'b0, decCnt[g]}));

    // R3
    rel_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clrMask[g] |-> (ents[g].live &&
        (ents[g].ovwDone || (ents[g].cnt == '0 && ents[g].inQ && ents[g].ovw))));

    // R7
    rel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.clrMask[g] |=> !ents[g].live);
  end

endmodule

// File: rtl/put_control.sv
module put_control
  import put_pkg::*;
#(
  parameter int REL_SLOTS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  entry_t [NUM_PREGS-1:0]               ents,
  output strobe_t                              strb,
  output logic [REL_SLOTS-1:0]                 relValid,
  output logic [REL_SLOTS-1:0][PREG_W-1:0]     relPreg,
  output logic [REL_SLOTS-1:0][INUM_W-1:0]     relInum,
  output logic [REL_SLOTS-1:0][LREG_W-1:0]     relLreg,
  output logic [REL_SLOTS-1:0][ROB_W-1:0]      relRobIdx,
  output logic [REL_SLOTS-1:0][QADDR_W-1:0]    relQAddr,
  output logic [REL_SLOTS-1:0]                 relDealloc
);

  logic [NUM_PREGS-1:0] elig;
  logic [NUM_PREGS-1:0] remain;
  logic [PREG_W-1:0]    pick;
  logic                 found;

  always_comb begin
    for (int i = 0; i < NUM_PREGS; i++)
      elig[i] = ents[i].live &&
                (ents[i].ovwDone || (ents[i].cnt == '0 && ents[i].inQ && ents[i].ovw));
  end

  // lowest-index-first selection, one pass per release slot
  always_comb begin
    remain       = elig;
    strb.clrMask = '0;
    relValid     = '0;
    relPreg      = '0;
    relInum      = '0;
    relLreg      = '0;
    relRobIdx    = '0;
    relQAddr     = '0;
    relDealloc   = '0;
    pick         = '0;
    found        = 1'b0;
    for (int k = 0; k < REL_SLOTS; k++) begin
      pick  = '0;
      found = 1'b0;
      for (int i = NUM_PREGS - 1; i >= 0; i--) begin
        if (remain[i]) begin
          pick  = PREG_W'(i);
          found = 1'b1;
        end
      end
      if (found) begin
        remain[pick]       = 1'b0;
        strb.clrMask[pick] = 1'b1;
        relValid[k]        = 1'b1;
        relPreg[k]         = pick;
        relInum[k]         = ents[pick].inum;
        relLreg[k]         = ents[pick].lreg;
        relRobIdx[k]       = ents[pick].robIdx;
        relQAddr[k]        = ents[pick].qAddr;
        relDealloc[k]      = !ents[pick].ovwDone;
      end
    end
  end

  // R6
  rel_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strb.clrMask) == $countones(relValid));

  for (genvar k = 1; k < REL_SLOTS; k++) begin : gSlotChk
    // R6
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      relValid[k] |-> (relValid[k-1] && relPreg[k] > relPreg[k-1]));
  end

endmodule

// File: rtl/preg_usage_table.sv
module preg_usage_table
  import put_pkg::*;
#(
  parameter int REL_SLOTS = 2,
  parameter int DISP_W    = 2,
  parameter int ISS_W     = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 allocValid,
  input  logic [PREG_W-1:0]                    allocPreg,
  input  logic [INUM_W-1:0]                    allocInum,
  input  logic [DISP_W-1:0]                    dispValid,
  input  logic [DISP_W-1:0][PREG_W-1:0]        dispPreg,
  input  logic [ISS_W-1:0]                     issValid,
  input  logic [ISS_W-1:0][PREG_W-1:0]         issPreg,
  input  logic                                 ovwValid,
  input  logic [PREG_W-1:0]                    ovwPreg,
  input  logic [LREG_W-1:0]                    ovwLreg,
  input  logic [ROB_W-1:0]                     ovwRobIdx,
  input  logic                                 commitValid,
  input  logic [PREG_W-1:0]                    commitPreg,
  input  logic [QADDR_W-1:0]                   commitQAddr,
  input  logic                                 ovwCommitValid,
  input  logic [PREG_W-1:0]                    ovwCommitPreg,
  input  logic                                 squashValid,
  output logic [REL_SLOTS-1:0]                 relValid,
  output logic [REL_SLOTS-1:0][PREG_W-1:0]     relPreg,
  output logic [REL_SLOTS-1:0][INUM_W-1:0]     relInum,
  output logic [REL_SLOTS-1:0][LREG_W-1:0]     relLreg,
  output logic [REL_SLOTS-1:0][ROB_W-1:0]      relRobIdx,
  output logic [REL_SLOTS-1:0][QADDR_W-1:0]    relQAddr,
  output logic [REL_SLOTS-1:0]                 relDealloc
);

  entry_t [NUM_PREGS-1:0] ents;
  strobe_t                strb;

  put_datapath #(.DISP_W(DISP_W), .ISS_W(ISS_W)) uDp (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocPreg(allocPreg), .allocInum(allocInum),
    .dispValid(dispValid), .dispPreg(dispPreg),
    .issValid(issValid), .issPreg(issPreg),
    .ovwValid(ovwValid), .ovwPreg(ovwPreg), .ovwLreg(ovwLreg), .ovwRobIdx(ovwRobIdx),
    .commitValid(commitValid), .commitPreg(commitPreg), .commitQAddr(commitQAddr),
    .ovwCommitValid(ovwCommitValid), .ovwCommitPreg(ovwCommitPreg),
    .squashValid(squashValid), .strb(strb), .ents(ents)
  );

  put_control #(.REL_SLOTS(REL_SLOTS)) uCtl (
    .clk(clk), .rst_n(rst_n), .ents(ents), .strb(strb),
    .relValid(relValid), .relPreg(relPreg), .relInum(relInum),
    .relLreg(relLreg), .relRobIdx(relRobIdx), .relQAddr(relQAddr),
    .relDealloc(relDealloc)
  );

endmodule

// File: tb/tb_preg_usage_table.sv
`timescale 1ns/1ps
module tb_preg_usage_table;
  import put_pkg::*;
  localparam int RS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allocValid; logic [PREG_W-1:0] allocPreg; logic [INUM_W-1:0] allocInum;
  logic [1:0] dispValid; logic [1:0][PREG_W-1:0] dispPreg;
  logic [1:0] issValid;  logic [1:0][PREG_W-1:0] issPreg;
  logic ovwValid; logic [PREG_W-1:0] ovwPreg; logic [LREG_W-1:0] ovwLreg; logic [ROB_W-1:0] ovwRobIdx;
  logic commitValid; logic [PREG_W-1:0] commitPreg; logic [QADDR_W-1:0] commitQAddr;
  logic ovwCommitValid; logic [PREG_W-1:0] ovwCommitPreg;
  logic squashValid;
  logic [RS-1:0] relValid, relDealloc;
  logic [RS-1:0][PREG_W-1:0] relPreg;
  logic [RS-1:0][INUM_W-1:0] relInum;
  logic [RS-1:0][LREG_W-1:0] relLreg;
  logic [RS-1:0][ROB_W-1:0] relRobIdx;
  logic [RS-1:0][QADDR_W-1:0] relQAddr;

  preg_usage_table #(.REL_SLOTS(RS), .DISP_W(2), .ISS_W(2)) dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [PREG_W-1:0] preg; logic [INUM_W-1:0] inum; logic [LREG_W-1:0] lreg;
    logic [ROB_W-1:0] rob; logic [QADDR_W-1:0] qa; logic dealloc; string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectRel(int p, int inum, int lreg, int rob, int qa, bit dea, string tag);
    exp_t e;
    e.preg = PREG_W'(p); e.inum = INUM_W'(inum); e.lreg = LREG_W'(lreg);
    e.rob = ROB_W'(rob); e.qa = QADDR_W'(qa); e.dealloc = dea; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic clearIns();
    allocValid = 0; allocPreg = '0; allocInum = '0;
    dispValid = '0; dispPreg = '0; issValid = '0; issPreg = '0;
    ovwValid = 0; ovwPreg = '0; ovwLreg = '0; ovwRobIdx = '0;
    commitValid = 0; commitPreg = '0; commitQAddr = '0;
    ovwCommitValid = 0; ovwCommitPreg = '0; squashValid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; clearIns(); end
  endtask

  task automatic doAlloc(int p, int inum);
    allocValid = 1; allocPreg = PREG_W'(p); allocInum = INUM_W'(inum); idle(1);
  endtask
  task automatic doCommit(int p, int qa);
    commitValid = 1; commitPreg = PREG_W'(p); commitQAddr = QADDR_W'(qa); idle(1);
  endtask
  task automatic doOvw(int p, int lreg, int rob);
    ovwValid = 1; ovwPreg = PREG_W'(p); ovwLreg = LREG_W'(lreg); ovwRobIdx = ROB_W'(rob); idle(1);
  endtask

  task automatic drained(string tag);
    check(expQ.size() == 0, tag, 64'(expQ.size()), 64'd0);
  endtask

  // monitor: pops the scoreboard for every release slot it sees
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < RS; k++) begin
        if (relValid[k]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "unexpected release", 64'(relPreg[k]), 64'hFFFF);
          end else begin
            exp_t e;
            logic [63:0] act, exv;
            e = expQ.pop_front();
            act = 64'({relPreg[k], relInum[k], relLreg[k], relRobIdx[k], relQAddr[k], relDealloc[k]});
            exv = 64'({e.preg, e.inum, e.lreg, e.rob, e.qa, e.dealloc});
            check(act == exv, e.tag, act, exv);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearIns();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);
    check(relValid == '0, "R1 reset quiet", 64'(relValid), 64'd0);

    // R3: committed, no overwrite -> held
    doAlloc(3, 8'h11);
    doCommit(3, 9);
    idle(2);
    check(relValid == '0, "R3 missing overwrite", 64'(relValid), 64'd0);
    // R4/R5: overwrite completes conditions
    expectRel(3, 8'h11, 7, 21, 9, 1'b1, "R5 eager payload");
    ovwValid = 1; ovwPreg = 4'd3; ovwLreg = 5'd7; ovwRobIdx = 7'd21;
    idle(1);
    check(relValid == 2'b01 && relPreg[0] == 4'd3, "R4 visible next cycle", 64'({relValid, relPreg[0]}), 64'h13);
    idle(1);
    check(relValid == '0, "R4 single cycle", 64'(relValid), 64'd0);

    // R3: overwrite seen, no commit -> held
    doAlloc(4, 8'h14);
    doOvw(4, 3, 24);
    idle(2);
    check(relValid == '0, "R3 missing commit", 64'(relValid), 64'd0);
    expectRel(4, 8'h14, 3, 24, 44, 1'b1, "R3 all three met");
    doCommit(4, 44);
    idle(2);
    drained("R3 drain");

    // R2: two readers pending
    doAlloc(5, 8'h25);
    doCommit(5, 5);
    dispValid = 2'b11; dispPreg[0] = 4'd5; dispPreg[1] = 4'd5; idle(1);
    doOvw(5, 5, 25);
    issValid = 2'b01; issPreg[0] = 4'd5; idle(1);
    idle(2);
    check(relValid == '0, "R2 one reader left", 64'(relValid), 64'd0);
    expectRel(5, 8'h25, 5, 25, 5, 1'b1, "R2 last reader left");
    issValid = 2'b10; issPreg[1] = 4'd5; idle(1);
    idle(2);
    drained("R2 drain");

    // R10: dispatch and issue in the same cycle
    doAlloc(6, 8'h36);
    doCommit(6, 6);
    dispValid = 2'b01; dispPreg[0] = 4'd6; idle(1);
    doOvw(6, 6, 26);
    dispValid = 2'b10; dispPreg[1] = 4'd6; issValid = 2'b01; issPreg[0] = 4'd6; idle(1);
    idle(2);
    check(relValid == '0, "R10 count unchanged", 64'(relValid), 64'd0);
    expectRel(6, 8'h36, 6, 26, 6, 1'b1, "R10 release after final issue");
    issValid = 2'b10; issPreg[1] = 4'd6; idle(1);
    idle(2);
    drained("R10 drain");

    // R6/R8: three eligible together, two slots
    doAlloc(10, 8'h3A);
    doAlloc(9, 8'h39);
    doAlloc(8, 8'h38);
    doCommit(8, 18);
    doCommit(9, 19);
    dispValid = 2'b11; dispPreg[0] = 4'd9; dispPreg[1] = 4'd8; idle(1);
    doOvw(9, 9, 41);
    doOvw(8, 8, 40);
    idle(1);
    check(relValid == '0, "R6 held by readers", 64'(relValid), 64'd0);
    expectRel(8, 8'h38, 8, 40, 18, 1'b1, "R6 slot0 lowest");
    expectRel(9, 8'h39, 9, 41, 19, 1'b1, "R6 slot1 next");
    expectRel(10, 8'h3A, 0, 0, 0, 1'b0, "R8 conventional release");
    issValid = 2'b11; issPreg[0] = 4'd9; issPreg[1] = 4'd8;
    ovwCommitValid = 1; ovwCommitPreg = 4'd10;
    idle(1);
    check(relValid == 2'b11 && relPreg[0] == 4'd8 && relPreg[1] == 4'd9, "R6 first cycle two",
          64'({relValid, relPreg[1], relPreg[0]}), 64'h398);
    idle(1);
    check(relValid == 2'b01 && relPreg[0] == 4'd10, "R6 remainder next cycle",
          64'({relValid, relPreg[0]}), 64'h1A);
    idle(2);
    drained("R6 drain");

    // R7: overwriter commit after early release, then reuse
    ovwCommitValid = 1; ovwCommitPreg = 4'd3; idle(1);
    idle(2);
    check(relValid == '0, "R7 no second release", 64'(relValid), 64'd0);
    doAlloc(3, 8'h53);
    doOvw(3, 2, 12);
    idle(2);
    check(relValid == '0, "R7 no stale commit state", 64'(relValid), 64'd0);
    expectRel(3, 8'h53, 2, 12, 50, 1'b1, "R7 reused entry");
    doCommit(3, 50);
    idle(2);
    drained("R7 drain");

    // R9: squash clears overwrite and count
    doAlloc(12, 8'h4C);
    doCommit(12, 12);
    dispValid = 2'b01; dispPreg[0] = 4'd12; idle(1);
    doOvw(12, 1, 31);
    squashValid = 1; idle(1);
    idle(2);
    check(relValid == '0, "R9 squash drops overwrite", 64'(relValid), 64'd0);
    expectRel(12, 8'h4C, 4, 30, 12, 1'b1, "R9 fresh overwrite");
    doOvw(12, 4, 30);
    idle(2);
    drained("R9 drain");

    // R11: overwriter commit in the release cycle
    doAlloc(13, 8'h5D);
    doCommit(13, 13);
    expectRel(13, 8'h5D, 13, 33, 13, 1'b1, "R11 single eager push");
    ovwValid = 1; ovwPreg = 4'd13; ovwLreg = 5'd13; ovwRobIdx = 7'd33;
    idle(1);
    ovwCommitValid = 1; ovwCommitPreg = 4'd13;
    idle(1);
    idle(3);
    check(relValid == '0, "R11 nothing after", 64'(relValid), 64'd0);
    drained("R11 drain");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule